// File: doc/BRIEF.md
# Tagged Memory Fill Engine

This block fills a region of memory with a single repeated byte and, for every 16-byte granule it fills, writes a 4-bit allocation tag taken from the region's address. The work is split across three calls, each started by a pulse on `start`: a prologue, a main stage and an epilogue. The caller passes the address, the byte count and the condition flags returned by one stage into the next stage. The prologue validates and normalises the arguments. The main stage does a bounded slice of the fill. The epilogue finishes whatever remains.

Two count conventions are supported. Under the end-relative convention, the prologue moves the address to the end of the region and negates the count. Each write then lands at address plus count, and the count rises toward zero. Under the start-relative convention, the address walks upward while a positive count falls. The prologue reports which convention it chose in the carry flag. The later stages read that flag back from `nzcv_in[1]`.

Work proceeds in chunks. Each chunk is one burst write on the data port. It is followed by one tag write per granule of that chunk, and the tag writes finish before the next burst begins. A burst that reports fewer bytes than requested stops the engine with a fault.

Top module: `tagfill_engine`

## Requirements
- R1: Every data write carries the low byte of `fill` replicated into all 16 bytes of `wr_data`.
- R2: Each data write has a length that is a nonzero multiple of 16, at most `CHUNK_BYTES` and at most the work left in the stage. Address and length hold steady until `wr_ack`.
- R3: In the prologue (`stage`=0), a count above 0x7FFFFFFFFFFFFFF0 is clamped to that value before any other step.
- R4: An alignment fault is raised when the count (after clamping) is not a multiple of 16, or when the count is nonzero and `addr_in[3:0]` is nonzero. On this fault `align_fault` is high, no write is issued, and `addr_out`, `count_out` and `nzcv_out` equal the raw inputs. The check applies in all stages.
- R5: In the prologue with `opt_b`=0, the outputs become address plus count, the negated count, and NZCV=0000. Writes go to address plus count, and the count rises toward zero.
- R6: In the prologue with `opt_b`=1, NZCV becomes 0010 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). Writes start at the address, the address grows and the count shrinks.
- R7: For each chunk, the tag is bits 59:56 of the chunk's first write address. It is written to each granule of the chunk from the highest granule down to the lowest, and the first tag write follows the accepted data write directly.
- R8: The prologue and main stages process at most `STAGE_BYTES` bytes. The epilogue (`stage`=2; code 3 acts as main) completes all remaining work, so a fault-free epilogue ends with a count of zero.
- R9: The main and epilogue stages treat the count as signed and take the convention from `nzcv_in[1]` (0 end-relative, 1 start-relative). A count whose sign does not match the convention yields no writes and unchanged outputs, and `nzcv_out` equals `nzcv_in`.
- R10: If `wr_done_bytes` is below the requested length, `write_fault` is raised, no tag is written for that chunk, and address and count reflect only the completed chunks.
- R11: After reset `busy`, `done` and both write strobes are low. `busy` rises the cycle after an accepted `start`, `done` pulses for one cycle at the end with `busy` falling after it, and `start` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a stage (sampled while idle) |
| stage | input | 2 | 0 prologue, 1 main, 2 epilogue |
| opt_b | input | 1 | Prologue convention select (1 start-relative) |
| nzcv_in | input | 4 | Flags from previous stage |
| addr_in | input | 64 | Destination address encoding |
| count_in | input | 64 | Byte count encoding |
| fill | input | 8 | Fill byte |
| busy | output | 1 | Stage in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_out | output | 64 | Updated address |
| count_out | output | 64 | Updated count |
| nzcv_out | output | 4 | Updated flags |
| align_fault | output | 1 | Alignment fault of last stage |
| write_fault | output | 1 | Short-write fault of last stage |
| wr_valid | output | 1 | Data write request |
| wr_addr | output | 64 | Data write start address |
| wr_len | output | 7 | Data write length in bytes |
| wr_data | output | 128 | Replicated fill pattern |
| wr_ack | input | 1 | Data write accepted |
| wr_done_bytes | input | 7 | Bytes actually written, valid with `wr_ack` |
| tag_valid | output | 1 | Tag write strobe |
| tag_addr | output | 64 | Granule address of tag write |
| tag_value | output | 4 | Allocation tag |

## Verification
The hardest situation to reach is a short write in the middle of a multi-chunk stage. Only there can the bench see that the completed chunks are committed, that the failed chunk gets no tag, and that the registers stop at the last good boundary. The bench memory model returns a shortened byte count when the write address equals a chosen fault address. By placing that address at the second chunk of an epilogue, and at the first chunk of an end-relative epilogue, the bench covers both the partial-progress case and the no-progress case. The full three-stage sequence is run under each convention, with the flags of one stage fed into the next, so the sign handling and the stage limit are both exercised.

// File: rtl/tagfill_engine.sv
module tagfill_engine #(
  parameter int CHUNK_BYTES = 64,
  parameter int STAGE_BYTES = 64,
  parameter int TAG_LSB     = 56
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [1:0]                         stage,
  input  logic                               opt_b,
  input  logic [3:0]                         nzcv_in,
  input  logic [63:0]                        addr_in,
  input  logic [63:0]                        count_in,
  input  logic [7:0]                         fill,
  output logic                               busy,
  output logic                               done,
  output logic [63:0]                        addr_out,
  output logic [63:0]                        count_out,
  output logic [3:0]                         nzcv_out,
  output logic                               align_fault,
  output logic                               write_fault,
  output logic                               wr_valid,
  output logic [63:0]                        wr_addr,
  output logic [$clog2(CHUNK_BYTES):0]       wr_len,
  output logic [127:0]                       wr_data,
  input  logic                               wr_ack,
  input  logic [$clog2(CHUNK_BYTES):0]       wr_done_bytes,
  output logic                               tag_valid,
  output logic [63:0]                        tag_addr,
  output logic [3:0]                         tag_value
);
  localparam int          LENW    = $clog2(CHUNK_BYTES) + 1;
  localparam int          GRW     = $clog2(CHUNK_BYTES / 16) + 1;
  localparam logic [63:0] CHUNK64 = 64'(CHUNK_BYTES);
  localparam logic [63:0] STAGE64 = 64'(STAGE_BYTES);
  localparam logic [63:0] CLAMP   = 64'h7FFF_FFFF_FFFF_FFF0;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_TAG, S_DONE} state_t;

  state_t          st;
  logic [63:0]     addr_q, cnt_q, rem_q;
  logic [3:0]      nzcv_q;
  logic            conv_b_q, align_q, wfault_q;
  logic [7:0]      fill_q;
  logic [GRW-1:0]  gran_q;

  logic            is_pro;
  logic [63:0]     pro_cnt, chk_cnt, prep_addr, prep_cnt, work, prep_rem;
  logic [3:0]      prep_nzcv;
  logic            misal, use_b;

  assign is_pro    = (stage == 2'd0);
  assign pro_cnt   = (count_in > CLAMP) ? CLAMP : count_in;
  assign chk_cnt   = is_pro ? pro_cnt : count_in;
  assign misal     = (chk_cnt[3:0] != 4'd0) || ((chk_cnt != 64'd0) && (addr_in[3:0] != 4'd0));
  assign use_b     = is_pro ? opt_b : nzcv_in[1];
  assign prep_addr = (is_pro && !opt_b) ? addr_in + pro_cnt : addr_in;
  assign prep_cnt  = is_pro ? (opt_b ? pro_cnt : 64'd0 - pro_cnt) : count_in;
  assign prep_nzcv = is_pro ? (opt_b ? 4'b0010 : 4'b0000) : nzcv_in;

  always_comb begin
    if (use_b) work = ($signed(prep_cnt) > 0) ? prep_cnt : 64'd0;
    else       work = ($signed(prep_cnt) < 0) ? 64'd0 - prep_cnt : 64'd0;
    prep_rem = ((stage != 2'd2) && (work > STAGE64)) ? STAGE64 : work;
  end

  logic [LENW-1:0] len;
  logic [63:0]     wa;

  assign len       = (rem_q > CHUNK64) ? LENW'(CHUNK_BYTES) : rem_q[LENW-1:0];
  assign wa        = conv_b_q ? addr_q : addr_q + cnt_q;

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign wr_valid  = (st == S_WRITE);
  assign tag_valid = (st == S_TAG);
  assign wr_addr   = wa;
  assign wr_len    = len;
  assign wr_data   = {16{fill_q}};
  assign tag_addr  = wa + (64'(gran_q - GRW'(1)) << 4);
  assign tag_value = wa[TAG_LSB+3:TAG_LSB];

  assign addr_out    = addr_q;
  assign count_out   = cnt_q;
  assign nzcv_out    = nzcv_q;
  assign align_fault = align_q;
  assign write_fault = wfault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      nzcv_q   <= '0;
      conv_b_q <= 1'b0;
      align_q  <= 1'b0;
      wfault_q <= 1'b0;
      fill_q   <= '0;
      gran_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wfault_q <= 1'b0;
          align_q  <= misal;
          fill_q   <= fill;
          if (misal) begin
            addr_q <= addr_in;
            cnt_q  <= count_in;
            nzcv_q <= nzcv_in;
            rem_q  <= '0;
            st     <= S_DONE;
          end else begin
            addr_q   <= prep_addr;
            cnt_q    <= prep_cnt;
            nzcv_q   <= prep_nzcv;
            conv_b_q <= use_b;
            rem_q    <= prep_rem;
            st       <= (prep_rem != 64'd0) ? S_WRITE : S_DONE;
          end
        end
        S_WRITE: if (wr_ack) begin
          if (wr_done_bytes == len) begin
            gran_q <= GRW'(len >> 4);
            st     <= S_TAG;
          end else begin
            wfault_q <= 1'b1;
            st       <= S_DONE;
          end
        end
        S_TAG: begin
          if (gran_q == GRW'(1)) begin
            if (conv_b_q) begin
              addr_q <= addr_q + 64'(len);
              cnt_q  <= cnt_q - 64'(len);
            end else begin
              cnt_q  <= cnt_q + 64'(len);
            end
            rem_q <= rem_q - 64'(len);
            st    <= (rem_q == 64'(len)) ? S_DONE : S_WRITE;
          end
          gran_q <= gran_q - GRW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagfill_engine_chk.sv
module tagfill_engine_chk #(
  parameter int CHUNK_BYTES = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic                         align_fault,
  input logic                         write_fault,
  input logic                         wr_valid,
  input logic [63:0]                  wr_addr,
  input logic [$clog2(CHUNK_BYTES):0] wr_len,
  input logic [127:0]                 wr_data,
  input logic                         wr_ack,
  input logic                         tag_valid,
  input logic [63:0]                  tag_addr
);
  assert_fill_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data == {16{wr_data[7:0]}});

  assert_chunk_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_len != 0) && (wr_len[3:0] == 4'd0) && (int'(wr_len) <= CHUNK_BYTES));

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_len));

  assert_align_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !wr_valid && !tag_valid);

  assert_tag_granule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> tag_addr[3:0] == 4'd0);

  assert_tag_descend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && $past(tag_valid) |-> tag_addr == $past(tag_addr) - 64'd16);

  assert_tag_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && !$past(tag_valid) |-> $past(wr_valid && wr_ack));

  assert_fault_no_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_fault |-> !tag_valid && !wr_valid);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind tagfill_engine tagfill_engine_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .align_fault(align_fault), .write_fault(write_fault),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
  .wr_ack(wr_ack), .tag_valid(tag_valid), .tag_addr(tag_addr));

// File: tb/tagfill_engine_bench.sv
`timescale 1ns/1ps
module tagfill_engine_bench;
  localparam int CH = 64;
  localparam int SB = 64;
  localparam int LW = $clog2(CH) + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, opt_b = 1'b0;
  logic [1:0] stage = '0;
  logic [3:0] nzcv_in = '0;
  logic [63:0] addr_in = '0, count_in = '0;
  logic [7:0] fill = '0;
  logic busy, done, align_fault, write_fault, wr_valid, tag_valid;
  logic [63:0] addr_out, count_out, wr_addr, tag_addr;
  logic [3:0] nzcv_out, tag_value;
  logic [LW-1:0] wr_len;
  logic [127:0] wr_data;
  logic wr_ack = 1'b0;
  logic [LW-1:0] wr_done_bytes = '0;

  int n_chk = 0, n_fail = 0;
  logic [63:0] fault_addr = '1;
  logic [7:0] cur_fill = '0;
  logic [63:0] q_wa[$]; int q_wl[$];
  logic [63:0] q_ta[$]; logic [3:0] q_tv[$];

  always #2 clk = ~clk;

  tagfill_engine #(.CHUNK_BYTES(CH), .STAGE_BYTES(SB)) u_tagfill_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .stage(stage), .opt_b(opt_b),
    .nzcv_in(nzcv_in), .addr_in(addr_in), .count_in(count_in), .fill(fill),
    .busy(busy), .done(done), .addr_out(addr_out), .count_out(count_out),
    .nzcv_out(nzcv_out), .align_fault(align_fault), .write_fault(write_fault),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_done_bytes(wr_done_bytes), .tag_valid(tag_valid),
    .tag_addr(tag_addr), .tag_value(tag_value));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor + memory model
  always @(negedge clk) begin
    if (rst_n && wr_valid && !wr_ack) begin
      if (q_wa.size() == 0) chk(0, "R2", "unexpected write", wr_addr, 0);
      else begin
        logic [63:0] ea; int el;
        ea = q_wa.pop_front(); el = q_wl.pop_front();
        chk(wr_addr == ea, "R5/R6", "write address", wr_addr, ea);
        chk(int'(wr_len) == el, "R2", "write length", wr_len, el);
        chk(wr_data == {16{cur_fill}}, "R1", "write data", wr_data, {16{cur_fill}});
      end
      wr_ack <= 1'b1;
      wr_done_bytes <= (wr_addr == fault_addr) ? wr_len - LW'(16) : wr_len;
    end else wr_ack <= 1'b0;
    if (rst_n && tag_valid) begin
      if (q_ta.size() == 0) chk(0, "R7", "unexpected tag", tag_addr, 0);
      else begin
        logic [63:0] ta; logic [3:0] tv;
        ta = q_ta.pop_front(); tv = q_tv.pop_front();
        chk(tag_addr == ta, "R7", "tag address", tag_addr, ta);
        chk(tag_value == tv, "R7", "tag value", tag_value, tv);
      end
    end
  end

  // driver with reference model
  task automatic run_op(input logic [1:0] stg, input bit ob, input logic [3:0] nz,
                        input logic [63:0] a, input logic [63:0] c, input logic [7:0] f,
                        input logic [63:0] fa, input int hold, input string req,
                        output logic [63:0] ra, output logic [63:0] rc, output logic [3:0] rn);
    logic [63:0] ma, mc, cc, rem, wa; logic [3:0] mn; bit conv_b, mis, ef;
    ma = a; mc = c; mn = nz; ef = 0;
    cc = (stg == 0 && c > 64'h7FFF_FFFF_FFFF_FFF0) ? 64'h7FFF_FFFF_FFFF_FFF0 : c;
    mis = (cc[3:0] != 0) || (cc != 0 && a[3:0] != 0);
    rem = 0; conv_b = (stg == 0) ? ob : nz[1];
    if (!mis) begin
      if (stg == 0) begin
        if (ob) begin mc = cc; mn = 4'b0010; end
        else begin ma = a + cc; mc = -cc; mn = 4'b0000; end
      end
      if (conv_b) rem = ($signed(mc) > 0) ? mc : 0;
      else rem = ($signed(mc) < 0) ? -mc : 0;
      if (stg != 2 && rem > SB) rem = SB;
      while (rem != 0 && !ef) begin
        int b;
        b = (rem > CH) ? CH : int'(rem);
        wa = conv_b ? ma : ma + mc;
        q_wa.push_back(wa); q_wl.push_back(b);
        if (wa == fa) ef = 1;
        else begin
          for (int k = b / 16; k > 0; k--) begin
            q_ta.push_back(wa + 64'((k - 1) * 16)); q_tv.push_back(wa[59:56]);
          end
          if (conv_b) begin ma = ma + 64'(b); mc = mc - 64'(b); end
          else mc = mc + 64'(b);
          rem = rem - 64'(b);
        end
      end
    end
    fault_addr = fa; cur_fill = f;
    stage = stg; opt_b = ob; nzcv_in = nz; addr_in = a; count_in = c; fill = f;
    start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(addr_out == ma, req, "addr_out", addr_out, ma);
    chk(count_out == mc, req, "count_out", count_out, mc);
    chk(nzcv_out == mn, req, "nzcv_out", nzcv_out, mn);
    chk(align_fault == mis, "R4", "align_fault", align_fault, mis);
    chk(write_fault == ef, "R10", "write_fault", write_fault, ef);
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after done", {busy, done}, 0);
    chk(q_wa.size() == 0 && q_ta.size() == 0, req, "pending scoreboard items",
        q_wa.size() + q_ta.size(), 0);
    ra = addr_out; rc = count_out; rn = nzcv_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ra, rc; logic [3:0] rn;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_valid && !tag_valid, "R11", "reset state",
        {busy, done, wr_valid, tag_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 single chunk end-relative
    run_op(0, 0, 4'hF, 64'h0A00_0000_0000_1000, 64'd48, 8'h5A, '1, 1, "R5", ra, rc, rn);
    chk(rc == 0 && rn == 0, "R5", "count zero flags 0000", {rc, rn}, 0);

    // R8 three stages, end-relative, 208 bytes
    run_op(0, 0, 4'h0, 64'h0300_0000_0000_2000, 64'd208, 8'hC3, '1, 1, "R8", ra, rc, rn);
    chk(rc == -64'd144, "R8", "prologue limited", rc, -64'd144);
    run_op(1, 0, rn, ra, rc, 8'hC3, '1, 1, "R9", ra, rc, rn);
    chk(rc == -64'd80, "R8", "main limited", rc, -64'd80);
    run_op(2, 0, rn, ra, rc, 8'hC3, '1, 1, "R8", ra, rc, rn);
    chk(rc == 0, "R8", "epilogue completes", rc, 0);

    // R6 three stages, start-relative, 160 bytes
    run_op(0, 1, 4'h0, 64'h0500_0000_0000_3000, 64'd160, 8'h11, '1, 1, "R6", ra, rc, rn);
    chk(rn == 4'b0010 && rc == 64'd96, "R6", "flags 0010 count", {rn, rc}, {4'b0010, 64'd96});
    run_op(1, 1, rn, ra, rc, 8'h11, '1, 1, "R9", ra, rc, rn);
    run_op(2, 1, rn, ra, rc, 8'h11, '1, 1, "R8", ra, rc, rn);
    chk(rc == 0 && ra == 64'h0500_0000_0000_30A0, "R8", "final addr", ra, 64'h0500_0000_0000_30A0);

    // R4 alignment faults
    run_op(0, 1, 4'h9, 64'h0000_0000_0000_4000, 64'd100, 8'h22, '1, 1, "R4", ra, rc, rn);
    run_op(0, 1, 4'h9, 64'h0000_0000_0000_4008, 64'd32, 8'h22, '1, 1, "R4", ra, rc, rn);
    run_op(1, 1, 4'h2, 64'h0000_0000_0000_4000, 64'd24, 8'h22, '1, 1, "R4", ra, rc, rn);
    run_op(0, 1, 4'h0, 64'h0000_0000_0000_4008, 64'd0, 8'h22, '1, 1, "R4", ra, rc, rn);

    // R3 clamp
    run_op(0, 1, 4'h0, 64'h0100_0000_0000_5000, 64'hFFFF_FFFF_FFFF_FFF0, 8'h77, '1, 1, "R3", ra, rc, rn);
    chk(rc == 64'h7FFF_FFFF_FFFF_FFB0, "R3", "clamped count", rc, 64'h7FFF_FFFF_FFFF_FFB0);

    // R9 sign mismatch
    run_op(1, 1, 4'h2, 64'h0000_0000_0000_6000, -64'd64, 8'h33, '1, 1, "R9", ra, rc, rn);
    run_op(2, 0, 4'h8, 64'h0000_0000_0000_6000, 64'd64, 8'h33, '1, 1, "R9", ra, rc, rn);

    // R10 short write mid-stage and at first chunk
    run_op(2, 1, 4'h2, 64'h0700_0000_0000_8000, 64'd128, 8'h99, 64'h0700_0000_0000_8040, 1, "R10", ra, rc, rn);
    chk(rc == 64'd64 && ra == 64'h0700_0000_0000_8040, "R10", "progress kept", {ra, rc},
        {64'h0700_0000_0000_8040, 64'd64});
    run_op(2, 0, 4'h0, 64'h0200_0000_0000_9060, -64'd96, 8'h44, 64'h0200_0000_0000_9000, 1, "R10", ra, rc, rn);

    // R11 start held while busy
    run_op(0, 1, 4'h0, 64'h0600_0000_0000_A000, 64'd64, 8'hE1, '1, 3, "R11", ra, rc, rn);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule